// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-facing engine of a byte-addressed serial memory that answers as a slave on a two-wire, I2C-compatible bus. It receives the clock and data lines already synchronised to a fast system clock. It detects bus conditions by comparing each line with its value one system cycle earlier. Every bit is sampled on a rising SCL and the slave changes its own data drive only after SCL has fallen. The output `sda_oe_o` is an open-drain enable: 1 pulls the line low.

A transfer opens with a control byte made of a fixed device code, block-select bits and a direction bit. In a write, the engine loads a word address into a single shared pointer and then hands each received data byte to an external write-buffer controller through a one-cycle strobe. It commits the buffer on STOP and discards it on a repeated START. In a read, it fetches bytes from the memory array at the pointer and shifts them out MSB first for as long as the master acknowledges. While the write-buffer controller reports an internal write in progress, the engine acknowledges nothing. A master can use this to poll for completion.

States: `ST_IDLE` (waits for START), `ST_CTRL` (receives control byte), `ST_CTRL_ACK` (acknowledges control byte), `ST_ADDR` / `ST_ADDR_ACK` (word address), `ST_DATA` / `ST_DATA_ACK` (write data), `ST_TX` (shifts a read byte out), `ST_HOST_ACK` (samples the master's acknowledge), `ST_TX_NEXT` (loads the next read byte at the SCL fall), and `ST_IGNORE` (stays silent until the next bus condition).

Transitions:
- Any state goes to `ST_CTRL` on START and to `ST_IDLE` on STOP.
- `ST_CTRL` goes to `ST_CTRL_ACK` on a matching code while not busy, and to `ST_IGNORE` otherwise.
- `ST_CTRL_ACK` goes to `ST_ADDR` for a write and to `ST_TX` for a read.
- `ST_ADDR` goes to `ST_ADDR_ACK`, then to `ST_DATA`.
- `ST_DATA` goes to `ST_DATA_ACK`, then back to `ST_DATA`.
- `ST_TX` goes to `ST_HOST_ACK` after eight bits.
- `ST_HOST_ACK` goes to `ST_TX_NEXT` when the master acknowledges, and to `ST_IGNORE` when it does not.
- `ST_TX_NEXT` goes to `ST_TX`.

Top module: `twi_mem_slave`

## Requirements
- R1: After reset, and one cycle after any STOP, the engine is idle and does not drive SDA. A START seen in any state makes the next byte be treated as a control byte.
- R2: A control byte has the form {code[3:0], blk[2:0], rw}, sent MSB first. When code is 4'b1010, the engine holds SDA low through the ninth clock. For any other code it gives no acknowledge and ignores every further bit until the next START or STOP.
- R3: While `wr_busy_i` is 1, a control byte gets no acknowledge, even when its code matches (read or write).
- R4: In a write, the pointer takes blk[1:0] (control bits 2:1) as address bits 9:8, and control bit 3 is ignored. The pointer takes the next byte as bits 7:0. Each following byte is acknowledged and presented with one `buf_wr_o` pulse, carrying the pointer as address. The pointer's low 4 bits then increment and wrap within the 16-byte page, and the upper bits are held.
- R5: A STOP after at least one data byte gives exactly one `buf_commit_o` pulse. A STOP after a transfer with no data byte gives none.
- R6: A repeated START right after the word address ends the write with no strobe, and the pointer keeps the new address. A repeated START after data bytes gives one `buf_discard_o` pulse and no commit.
- R7: A read control byte sets pointer bits 9:8 from blk. The engine then sends the byte at the pointer, MSB first, and increments the pointer after each byte sent. A current-address read therefore returns the byte after the last one accessed.
- R8: When the master acknowledges, the next sequential byte follows. The pointer wraps from 0x3FF to 0x000.
- R9: When the master does not acknowledge, the engine releases SDA and keeps it released until the next START or STOP.
- R10: A START or STOP in the middle of a byte aborts it. A partial address byte leaves the pointer unchanged.
- R11: `sda_oe_o` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised serial clock |
| sda_i | input | 1 | Synchronised serial data (bus level) |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| wr_busy_i | input | 1 | Internal write cycle in progress |
| rd_addr_o | output | ADDR_W | Array read address (the pointer) |
| rd_data_i | input | 8 | Array read data for `rd_addr_o` |
| buf_wr_o | output | 1 | One-cycle strobe: data byte for the write buffer |
| buf_addr_o | output | ADDR_W | Target address of the strobed byte |
| buf_data_o | output | 8 | Strobed data byte |
| buf_commit_o | output | 1 | One-cycle strobe: start the internal write |
| buf_discard_o | output | 1 | One-cycle strobe: drop buffered bytes |

## Verification
Bus conditions and SCL edges are seen in the same system cycle in which the synchronised line changes. `sda_oe_o` and the three strobes are therefore registered one cycle after an SCL fall or a STOP. A read byte's first bit is valid one cycle after the SCL fall that closes the acknowledge slot. The bench drives its lines at falling system-clock edges and holds each SCL phase for several cycles. It samples SDA only in the middle of the SCL high phase, long after any response is due. It counts strobes and checks SDA stability at rising edges.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTRL,
        ST_CTRL_ACK,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_TX,
        ST_HOST_ACK,
        ST_TX_NEXT,
        ST_IGNORE
    } eng_state_t;

    localparam logic [3:0] DEV_CODE = 4'b1010;

endpackage

// File: rtl/twi_bus_monitor.sv
module twi_bus_monitor (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise  = scl_i & ~scl_q;
    assign scl_fall  = ~scl_i & scl_q;
    // data edges while the clock stays high are bus conditions
    assign start_det = scl_i & scl_q & sda_q & ~sda_i;
    assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/twi_byte_shifter.sv
module twi_byte_shifter #(
    parameter int BITS = 8,
    parameter int CW   = $clog2(BITS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            load,
    input  logic [BITS-1:0] load_val,
    input  logic            tick,
    input  logic            shift_in,
    input  logic            bit_in,
    input  logic            shift_out,
    output logic [BITS-1:0] q,
    output logic [CW-1:0]   cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q   <= '0;
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (load) begin
            q   <= load_val;
            cnt <= '0;
        end else begin
            if (tick)
                cnt <= cnt + CW'(1);
            if (shift_in)
                q <= {q[BITS-2:0], bit_in};
            else if (shift_out)
                q <= {q[BITS-2:0], 1'b0};
        end
    end

    // a byte never counts past its width; aborts clear it (R10)
    p_bitcnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(BITS));

endmodule

// File: rtl/twi_addr_ptr.sv
module twi_addr_ptr #(
    parameter int AW = 10,
    parameter int PW = 4,
    parameter int BW = AW - 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_blk,
    input  logic [BW-1:0] blk_val,
    input  logic          ld_low,
    input  logic [7:0]    low_val,
    input  logic          inc_page,
    input  logic          inc_full,
    output logic [AW-1:0] ptr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else begin
            if (ld_blk)
                ptr[AW-1:8] <= blk_val;
            if (ld_low)
                ptr[7:0] <= low_val;
            if (inc_page)
                ptr[PW-1:0] <= ptr[PW-1:0] + PW'(1);
            if (inc_full)
                ptr <= ptr + AW'(1);
        end
    end

    p_page_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        inc_page |=> (ptr[AW-1:PW] == $past(ptr[AW-1:PW]))
                     && (ptr[PW-1:0] == $past(ptr[PW-1:0]) + PW'(1)));

    p_top_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_full && ptr == '1) |=> ptr == '0);

endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
    import twi_mem_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic              wr_busy_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [7:0]        rd_data_i,
    output logic              buf_wr_o,
    output logic [ADDR_W-1:0] buf_addr_o,
    output logic [7:0]        buf_data_o,
    output logic              buf_commit_o,
    output logic              buf_discard_o
);
    localparam int BYTE_W = 8;
    localparam int BLK_W  = ADDR_W - 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    eng_state_t state, nxt;

    logic scl_rise, scl_fall, start_det, stop_det;
    logic [BYTE_W-1:0] sh_q;
    logic [CNT_W-1:0]  sh_cnt;
    logic [ADDR_W-1:0] ptr;

    logic sh_clr, sh_load, sh_tick, sh_in, sh_out;
    logic p_blk, p_low, p_page, p_full;
    logic oe_set, oe_clr, wr_stb, do_commit, do_discard, rw_load;
    logic rw_q, pending;
    logic byte_done, code_ok;

    twi_bus_monitor u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    twi_byte_shifter #(.BITS(BYTE_W), .CW(CNT_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (sh_clr),
        .load      (sh_load),
        .load_val  (rd_data_i),
        .tick      (sh_tick),
        .shift_in  (sh_in),
        .bit_in    (sda_i),
        .shift_out (sh_out),
        .q         (sh_q),
        .cnt       (sh_cnt)
    );

    twi_addr_ptr #(.AW(ADDR_W), .PW(PAGE_W), .BW(BLK_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_blk   (p_blk),
        .blk_val  (sh_q[BLK_W:1]),
        .ld_low   (p_low),
        .low_val  (sh_q),
        .inc_page (p_page),
        .inc_full (p_full),
        .ptr      (ptr)
    );

    assign rd_addr_o = ptr;
    assign byte_done = scl_fall && (sh_cnt == CNT_W'(BYTE_W));
    assign code_ok   = (sh_q[7:4] == DEV_CODE);

    // next state and datapath controls
    always_comb begin
        nxt        = state;
        sh_clr     = 1'b0;
        sh_load    = 1'b0;
        sh_tick    = 1'b0;
        sh_in      = 1'b0;
        sh_out     = 1'b0;
        p_blk      = 1'b0;
        p_low      = 1'b0;
        p_page     = 1'b0;
        p_full     = 1'b0;
        oe_set     = 1'b0;
        oe_clr     = 1'b0;
        wr_stb     = 1'b0;
        do_commit  = 1'b0;
        do_discard = 1'b0;
        rw_load    = 1'b0;
        if (start_det) begin
            nxt        = ST_CTRL;
            sh_clr     = 1'b1;
            oe_clr     = 1'b1;
            do_discard = pending;
        end else if (stop_det) begin
            nxt       = ST_IDLE;
            sh_clr    = 1'b1;
            oe_clr    = 1'b1;
            do_commit = pending;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_CTRL: begin
                    if (scl_rise) begin
                        sh_tick = 1'b1;
                        sh_in   = 1'b1;
                    end else if (byte_done) begin
                        if (code_ok && !wr_busy_i) begin
                            oe_set  = 1'b1;
                            p_blk   = 1'b1;
                            rw_load = 1'b1;
                            nxt     = ST_CTRL_ACK;
                        end else begin
                            nxt = ST_IGNORE;
                        end
                    end
                end
                ST_CTRL_ACK: begin
                    if (scl_fall) begin
                        if (rw_q) begin
                            sh_load = 1'b1;
                            p_full  = 1'b1;
                            nxt     = ST_TX;
                        end else begin
                            sh_clr = 1'b1;
                            oe_clr = 1'b1;
                            nxt    = ST_ADDR;
                        end
                    end
                end
                ST_ADDR: begin
                    if (scl_rise) begin
                        sh_tick = 1'b1;
                        sh_in   = 1'b1;
                    end else if (byte_done) begin
                        oe_set = 1'b1;
                        p_low  = 1'b1;
                        nxt    = ST_ADDR_ACK;
                    end
                end
                ST_ADDR_ACK, ST_DATA_ACK: begin
                    if (scl_fall) begin
                        sh_clr = 1'b1;
                        oe_clr = 1'b1;
                        nxt    = ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (scl_rise) begin
                        sh_tick = 1'b1;
                        sh_in   = 1'b1;
                    end else if (byte_done) begin
                        oe_set = 1'b1;
                        wr_stb = 1'b1;
                        p_page = 1'b1;
                        nxt    = ST_DATA_ACK;
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        sh_tick = 1'b1;
                    end else if (byte_done) begin
                        oe_clr = 1'b1;
                        nxt    = ST_HOST_ACK;
                    end else if (scl_fall) begin
                        sh_out = 1'b1;
                    end
                end
                ST_HOST_ACK: begin
                    if (scl_rise)
                        nxt = sda_i ? ST_IGNORE : ST_TX_NEXT;
                end
                ST_TX_NEXT: begin
                    if (scl_fall) begin
                        sh_load = 1'b1;
                        p_full  = 1'b1;
                        nxt     = ST_TX;
                    end
                end
                ST_IGNORE: ;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe_o      <= 1'b0;
            buf_wr_o      <= 1'b0;
            buf_addr_o    <= '0;
            buf_data_o    <= '0;
            buf_commit_o  <= 1'b0;
            buf_discard_o <= 1'b0;
            rw_q          <= 1'b0;
            pending       <= 1'b0;
        end else begin
            buf_wr_o      <= wr_stb;
            buf_commit_o  <= do_commit;
            buf_discard_o <= do_discard;
            if (wr_stb) begin
                buf_addr_o <= ptr;
                buf_data_o <= sh_q;
            end
            if (rw_load)
                rw_q <= sh_q[0];
            if (start_det || stop_det)
                pending <= 1'b0;
            else if (wr_stb)
                pending <= 1'b1;
            if (oe_set)
                sda_oe_o <= 1'b1;
            else if (oe_clr)
                sda_oe_o <= 1'b0;
            else if (sh_load)
                sda_oe_o <= ~rd_data_i[BYTE_W-1];
            else if (sh_out)
                sda_oe_o <= ~sh_q[BYTE_W-2];
        end
    end

    p_start_ctrl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_CTRL) && !sda_oe_o);

    p_stop_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE) && !sda_oe_o);

    p_bad_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CTRL && byte_done && !code_ok) |=> !sda_oe_o);

    p_busy_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CTRL && byte_done && wr_busy_i) |=> !sda_oe_o);

    p_commit_on_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        buf_commit_o |-> $past(stop_det));

    p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !$past(scl_i));

endmodule

// File: tb/tb_twi_mem_slave.sv
module tb_twi_mem_slave;
    localparam int AW = 10;
    localparam int Q = 4;
    localparam int BUSY_CYC = 600;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    wire  sda_bus = sda_m & ~sda_oe;
    wire  wr_busy;
    logic [AW-1:0] rd_addr;
    wire  [7:0] rd_data;
    logic buf_wr, buf_commit, buf_discard;
    logic [AW-1:0] buf_addr;
    logic [7:0] buf_data;

    twi_mem_slave #(.ADDR_W(AW), .PAGE_W(4)) dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .sda_oe_o(sda_oe), .wr_busy_i(wr_busy),
        .rd_addr_o(rd_addr), .rd_data_i(rd_data),
        .buf_wr_o(buf_wr), .buf_addr_o(buf_addr), .buf_data_o(buf_data),
        .buf_commit_o(buf_commit), .buf_discard_o(buf_discard)
    );

    function automatic logic [7:0] init_byte(int i);
        return 8'((i * 37) ^ (i >> 2) ^ 8'h5A);
    endfunction

    // environment: array plus write buffer controller
    logic [7:0] mem [0:(1<<AW)-1];
    logic [AW-1:0] q_addr [0:63];
    logic [7:0] q_data [0:63];
    int q_n = 0, busy_cnt = 0, wr_pulses = 0, commits = 0, discards = 0;
    assign rd_data = mem[rd_addr];
    assign wr_busy = (busy_cnt != 0);

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < (1<<AW); i++) mem[i] <= init_byte(i);
        end else begin
            if (buf_wr) begin
                wr_pulses <= wr_pulses + 1;
                if (q_n < 64) begin
                    q_addr[q_n] <= buf_addr;
                    q_data[q_n] <= buf_data;
                    q_n <= q_n + 1;
                end
            end
            if (buf_discard) begin
                q_n <= 0;
                discards <= discards + 1;
            end
            if (buf_commit) begin
                for (int i = 0; i < q_n; i++) mem[q_addr[i]] <= q_data[i];
                q_n <= 0;
                commits <= commits + 1;
                busy_cnt <= BUSY_CYC;
            end else if (busy_cnt > 0) begin
                busy_cnt <= busy_cnt - 1;
            end
        end
    end

    // SDA drive must not move while SCL stays high
    logic scl_prev = 1'b1, oe_prev = 1'b0;
    int viol = 0;
    always @(posedge clk) begin
        if (rst_n && scl && scl_prev && (sda_oe !== oe_prev)) viol <= viol + 1;
        scl_prev <= scl;
        oe_prev <= sda_oe;
    end

    int n_chk = 0, n_fail = 0;
    logic [7:0] exp_mem [0:(1<<AW)-1];
    logic [AW-1:0] ptr_m = '0;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_start();
        sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic m_stop();
        sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(2 * Q);
    endtask

    task automatic wbit(input logic b);
        sda_m = b; tick(Q); scl = 1'b1; tick(2 * Q); scl = 1'b0; tick(Q);
    endtask

    task automatic rbit(output logic b);
        sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); b = sda_bus; tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) wbit(v[i]);
        rbit(b);
        ack = !b;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            rbit(b);
            v[i] = b;
        end
        wbit(!mack);
    endtask

    // control byte layout {1010, blk[2:0], rw}; blk[2] is random and ignored
    task automatic ctrl_byte(input logic [1:0] blk, input logic rw, output logic ack);
        send_byte({4'b1010, 1'($urandom % 2), blk, rw}, ack);
    endtask

    task automatic poll(input logic [1:0] blk, input logic rd_probe);
        logic ack;
        int tries = 0;
        if (rd_probe) begin
            m_start(); ctrl_byte(blk, 1'b1, ack); m_stop();
            check("R3", "read control acked while busy", ack, 0);
        end
        do begin
            m_start(); ctrl_byte(blk, 1'b0, ack); m_stop();
            if (tries == 0) check("R3", "write control acked while busy", ack, 0);
            tries++;
        end while (!ack && tries < 40);
        check("R3", "ack once write done", ack, 1);
        ptr_m[9:8] = blk;
    endtask

    task automatic op_write(input logic [1:0] blk, input logic [7:0] a, input int len, input logic rd_probe);
        logic ack;
        logic [7:0] d;
        m_start();
        ctrl_byte(blk, 1'b0, ack); check("R2", "write control ack", ack, 1);
        send_byte(a, ack); check("R4", "address ack", ack, 1);
        for (int i = 0; i < len; i++) begin
            d = 8'($urandom);
            send_byte(d, ack); check("R4", "data ack", ack, 1);
            exp_mem[{blk, a[7:4], 4'(a[3:0] + i)}] = d;
        end
        ptr_m = {blk, a[7:4], 4'(a[3:0] + len)};
        m_stop();
        if (len > 0) poll(blk, rd_probe);
    endtask

    task automatic read_seq(input int len, input string req);
        logic [7:0] d;
        for (int i = 0; i < len; i++) begin
            recv_byte(i < len - 1, d);
            check(req, "read byte", d, exp_mem[ptr_m]);
            ptr_m = ptr_m + 1'b1;
        end
        m_stop();
    endtask

    task automatic op_rand_read(input logic [1:0] blk, input logic [7:0] a, input int len);
        logic ack;
        m_start();
        ctrl_byte(blk, 1'b0, ack); check("R2", "control ack", ack, 1);
        send_byte(a, ack); check("R6", "address ack", ack, 1);
        m_start();
        ctrl_byte(blk, 1'b1, ack); check("R7", "read control ack", ack, 1);
        ptr_m = {blk, a};
        read_seq(len, "R8");
    endtask

    task automatic op_cur_read(input logic [1:0] blk, input int len);
        logic ack;
        m_start();
        ctrl_byte(blk, 1'b1, ack); check("R7", "read control ack", ack, 1);
        ptr_m[9:8] = blk;
        read_seq(len, "R7");
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic ack, b;
        logic [7:0] d;
        int c0, w0, d0;
        void'($urandom(32'h1234));
        for (int i = 0; i < (1<<AW); i++) exp_mem[i] = init_byte(i);
        tick(10);
        rst_n = 1'b1;
        tick(4);
        check("R1", "sda_oe after reset", sda_oe, 0);
        check("R1", "no strobes after reset", buf_wr | buf_commit | buf_discard, 0);

        // byte write with busy probes, then verify
        op_write(2'd1, 8'h23, 1, 1'b1);
        op_rand_read(2'd1, 8'h23, 1);

        // page write past 16 bytes rolls inside the page
        op_write(2'd2, 8'hFA, 20, 1'b0);
        op_cur_read(2'd2, 2);
        op_rand_read(2'd2, 8'hF0, 16);

        // sequential read wraps at the top of the array
        op_rand_read(2'd3, 8'hFE, 3);
        check("R8", "pointer model wrapped", ptr_m, 1);
        op_cur_read(2'd0, 1);

        // wrong device code: silent and ignored
        w0 = wr_pulses;
        m_start();
        send_byte(8'hB4, ack); check("R2", "bad code ack", ack, 0);
        send_byte(8'h00, ack); check("R2", "byte after bad code ack", ack, 0);
        send_byte(8'h5C, ack); check("R2", "data after bad code ack", ack, 0);
        m_stop();
        check("R2", "no write strobe after bad code", wr_pulses, w0);
        op_cur_read(ptr_m[9:8], 1);

        // address only, STOP: no commit, not busy
        c0 = commits;
        m_start(); ctrl_byte(2'd1, 1'b0, ack); send_byte(8'h40, ack); m_stop();
        ptr_m = {2'd1, 8'h40};
        check("R5", "no commit without data", commits, c0);
        m_start(); ctrl_byte(2'd1, 1'b0, ack); m_stop();
        check("R5", "no busy without data", ack, 1);

        // address then repeated START: random read
        op_rand_read(2'd1, 8'h55, 1);
        check("R6", "no commit on address-only restart", commits, c0);

        // data then repeated START: discard
        d0 = discards;
        m_start();
        ctrl_byte(2'd0, 1'b0, ack);
        send_byte(8'h10, ack);
        send_byte(8'hC3, ack); check("R4", "data ack before restart", ack, 1);
        m_start();
        ctrl_byte(2'd0, 1'b1, ack); check("R6", "read control after restart", ack, 1);
        ptr_m = {2'd0, 8'h11};
        read_seq(1, "R6");
        check("R6", "discard pulse", discards, d0 + 1);
        check("R6", "no commit after discard", commits, c0);
        op_rand_read(2'd0, 8'h10, 1);

        // STOP in the middle of an address byte
        m_start(); ctrl_byte(2'd3, 1'b0, ack);
        wbit(1'b1); wbit(1'b0); wbit(1'b1);
        m_stop();
        check("R10", "sda released after abort", sda_oe, 0);
        ptr_m[9:8] = 2'd3;
        op_cur_read(2'd3, 1);
        // START in the middle of an address byte
        m_start(); ctrl_byte(2'd2, 1'b0, ack);
        wbit(1'b0); wbit(1'b1); wbit(1'b1); wbit(1'b0);
        m_start();
        ctrl_byte(2'd2, 1'b1, ack); check("R10", "read after mid-byte START", ack, 1);
        ptr_m[9:8] = 2'd2;
        read_seq(1, "R10");

        // master NACK: line stays released
        m_start(); ctrl_byte(2'd1, 1'b1, ack);
        ptr_m[9:8] = 2'd1;
        recv_byte(1'b0, d);
        check("R7", "byte before nack", d, exp_mem[ptr_m]);
        ptr_m = ptr_m + 1'b1;
        check("R9", "sda_oe after nack", sda_oe, 0);
        rbit(b); check("R9", "bus high after nack", b, 1);
        rbit(b); check("R9", "bus still high", b, 1);
        m_stop();
        check("R1", "idle after stop", sda_oe, 0);

        // mixed random traffic
        for (int k = 0; k < 24; k++) begin
            case ($urandom % 3)
                0: op_write(2'($urandom), 8'($urandom), 1 + int'($urandom % 20), 1'b0);
                1: op_rand_read(2'($urandom), 8'($urandom), 1 + int'($urandom % 4));
                default: op_cur_read(2'($urandom), 1 + int'($urandom % 3));
            endcase
        end

        check("R11", "sda_oe changes while SCL high", viol, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule